// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is the execution core of a small processor: seven general registers, two operand selectors, an arithmetic/logic unit and a destination decoder. It has no sequencer of its own. An external controller presents one 14-bit control word per clock, and that word fully defines the transfer carried out in that cycle: which two values enter the ALU, which function is applied, and where the result goes. A complete transfer such as "R1 gets R2 minus R3" takes exactly one clock.

Either operand may come from an external data input instead of a register. The destination may be a register, or no register at all. The ALU result is always driven on the data output, so the controller can read a register or pass input data straight through without changing any state. Four status flags (carry, sign, zero, overflow) describe the result of the previous cycle.

Top module: `cwdp_core`

## Requirements
- R1: The control word layout is: bits [13:11] select operand A, bits [10:8] select operand B, bits [7:5] select the destination, and bits [4:0] select the ALU function.
- R2: A source select code of 000 takes the operand from `data_in`. Codes 001 through 111 take it from registers R1 through R7.
- R3: A destination code k from 001 to 111 loads the ALU result into register Rk on the rising clock edge that ends the cycle. All other registers keep their values.
- R4: Destination code 000 loads no register, and the result is still driven on `data_out`.
- R5: `data_out` shows the ALU result for the control word and inputs of the same cycle, with no register stage in the path.
- R6: The arithmetic function codes, all modulo 2^W, are: 00000 gives A; 00001 gives A+1; 00010 gives A+B; 00101 gives A−B; 00110 gives A−1.
- R7: The logic function codes are: 01000 gives A AND B; 01010 gives A OR B; 01100 gives A XOR B; 01110 gives NOT A.
- R8: Code 10000 shifts A right by one and code 11000 shifts A left by one, each filling the vacated bit with 0. The carry flag takes the bit shifted out, and overflow is cleared.
- R9: Every function code not listed in R6 to R8 behaves as code 00000 (A passes through).
- R10: All four flags are registered on every rising edge from that cycle's result. The sign flag is the result MSB and the zero flag is set when the result is all zeros.
- R11: For codes 00001, 00010, 00101 and 00110, the carry flag is the carry out of an adder that computes A+1, A+B, A+(NOT B)+1 and A+(all ones) respectively. The overflow flag is set on two's-complement overflow. Codes 00000, 01000, 01010, 01100, 01110 and the unlisted codes clear both carry and overflow.
- R12: An active-low `rst_n` clears R1 through R7 and all flags, asynchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_word | input | 14 | Control word for the current cycle |
| data_in | input | W | External operand source |
| data_out | output | W | ALU result of the current cycle |
| flag_c | output | 1 | Carry flag from the previous cycle |
| flag_s | output | 1 | Sign flag from the previous cycle |
| flag_z | output | 1 | Zero flag from the previous cycle |
| flag_v | output | 1 | Overflow flag from the previous cycle |

## Verification
`data_out` is combinational, so the bench drives each control word on the falling edge and checks the result 2 ns later, within the same cycle. A register write and the flags both take effect on the next rising edge. The bench therefore checks the flags 1 ns after that edge. It checks a register write through a later pass-through word (function 00000, destination 000), which shows the register on `data_out` in that later cycle. An asynchronous reset asserted in the middle of the run is checked 1 ns after it falls, without waiting for a clock.

// File: rtl/cwdp_pkg.sv
package cwdp_pkg;

  localparam int SEL_W    = 3;
  localparam int FN_W     = 5;
  localparam int CTL_W    = 3 * SEL_W + FN_W;
  localparam int NUM_REGS = (1 << SEL_W) - 1;

  typedef enum logic [FN_W-1:0] {
    FN_PASS = 5'b00000,
    FN_INC  = 5'b00001,
    FN_ADD  = 5'b00010,
    FN_SUB  = 5'b00101,
    FN_DEC  = 5'b00110,
    FN_AND  = 5'b01000,
    FN_OR   = 5'b01010,
    FN_XOR  = 5'b01100,
    FN_NOT  = 5'b01110,
    FN_SHR  = 5'b10000,
    FN_SHL  = 5'b11000
  } alu_fn_e;

  typedef struct packed {
    logic [SEL_W-1:0] src_a;
    logic [SEL_W-1:0] src_b;
    logic [SEL_W-1:0] dst;
    logic [FN_W-1:0]  fn;
  } ctl_word_t;

endpackage

// File: rtl/cwdp_regfile.sv
module cwdp_regfile
  import cwdp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [W-1:0]          ext_in,
  input  logic [SEL_W-1:0]      rd_sel_a,
  input  logic [SEL_W-1:0]      rd_sel_b,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [W-1:0]          wr_data,
  output logic [W-1:0]          rd_a,
  output logic [W-1:0]          rd_b,
  output logic [NUM_REGS*W-1:0] q_flat
);

  // Read table: slot 0 is the external input, slots 1..N are registers
  logic [W-1:0] rd_tab [0:NUM_REGS];

  assign rd_tab[0] = ext_in;

  for (genvar i = 1; i <= NUM_REGS; i++) begin : g_reg
    logic         wr_en;
    logic [W-1:0] q;

    assign wr_en = (wr_sel == SEL_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (wr_en) begin
        q <= wr_data;
      end
    end

    assign rd_tab[i]             = q;
    assign q_flat[(i-1)*W +: W]  = q;
  end

  assign rd_a = rd_tab[rd_sel_a];
  assign rd_b = rd_tab[rd_sel_b];

endmodule

// File: rtl/cwdp_alu.sv
module cwdp_alu
  import cwdp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [FN_W-1:0] fn,
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  output logic [W-1:0]    res,
  output logic            cry,
  output logic            ovf
);

  logic [W-1:0] add_x;
  logic [W-1:0] add_y;
  logic         add_cin;
  logic [W:0]   add_sum;
  logic         add_c_msb;
  logic         use_adder;

  // Operand steering for the shared adder
  always_comb begin
    add_x     = opa;
    add_y     = '0;
    add_cin   = 1'b0;
    use_adder = 1'b1;
    unique case (alu_fn_e'(fn))
      FN_INC:  add_cin = 1'b1;
      FN_ADD:  add_y   = opb;
      FN_SUB:  begin add_y = ~opb; add_cin = 1'b1; end
      FN_DEC:  add_y   = '1;
      default: use_adder = 1'b0;
    endcase
  end

  assign add_sum   = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_cin};
  // carry into the MSB recovered from the MSB sum bit and its two inputs
  assign add_c_msb = add_sum[W-1] ^ add_x[W-1] ^ add_y[W-1];

  always_comb begin
    res = opa;
    cry = 1'b0;
    ovf = 1'b0;
    if (use_adder) begin
      res = add_sum[W-1:0];
      cry = add_sum[W];
      ovf = add_sum[W] ^ add_c_msb;
    end else begin
      unique case (alu_fn_e'(fn))
        FN_AND:  res = opa & opb;
        FN_OR:   res = opa | opb;
        FN_XOR:  res = opa ^ opb;
        FN_NOT:  res = ~opa;
        FN_SHR:  begin res = {1'b0, opa[W-1:1]}; cry = opa[0];   end
        FN_SHL:  begin res = {opa[W-2:0], 1'b0}; cry = opa[W-1]; end
        default: res = opa;
      endcase
    end
  end

endmodule

// File: rtl/cwdp_status.sv
module cwdp_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] res,
  input  logic         cry,
  input  logic         ovf,
  output logic         st_c,
  output logic         st_s,
  output logic         st_z,
  output logic         st_v
);

  logic c_nxt, s_nxt, z_nxt, v_nxt;

  always_comb begin
    c_nxt = cry;
    s_nxt = res[W-1];
    z_nxt = (res == '0);
    v_nxt = ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_c <= 1'b0;
      st_s <= 1'b0;
      st_z <= 1'b0;
      st_v <= 1'b0;
    end else begin
      st_c <= c_nxt;
      st_s <= s_nxt;
      st_z <= z_nxt;
      st_v <= v_nxt;
    end
  end

endmodule

// File: rtl/cwdp_core.sv
module cwdp_core
  import cwdp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] ctl_word,
  input  logic [W-1:0]     data_in,
  output logic [W-1:0]     data_out,
  output logic             flag_c,
  output logic             flag_s,
  output logic             flag_z,
  output logic             flag_v
);

  ctl_word_t             cw;
  logic [W-1:0]          bus_a;
  logic [W-1:0]          bus_b;
  logic [W-1:0]          alu_res;
  logic                  alu_c;
  logic                  alu_v;
  logic [NUM_REGS*W-1:0] rf_q;

  assign cw = ctl_word_t'(ctl_word);

  cwdp_regfile #(.W(W)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_in   (data_in),
    .rd_sel_a (cw.src_a),
    .rd_sel_b (cw.src_b),
    .wr_sel   (cw.dst),
    .wr_data  (alu_res),
    .rd_a     (bus_a),
    .rd_b     (bus_b),
    .q_flat   (rf_q)
  );

  cwdp_alu #(.W(W)) u_alu (
    .fn  (cw.fn),
    .opa (bus_a),
    .opb (bus_b),
    .res (alu_res),
    .cry (alu_c),
    .ovf (alu_v)
  );

  cwdp_status #(.W(W)) u_st (
    .clk   (clk),
    .rst_n (rst_n),
    .res   (alu_res),
    .cry   (alu_c),
    .ovf   (alu_v),
    .st_c  (flag_c),
    .st_s  (flag_s),
    .st_z  (flag_z),
    .st_v  (flag_v)
  );

  assign data_out = alu_res;

endmodule

// File: rtl/cwdp_chk.sv
module cwdp_chk
  import cwdp_pkg::*;
#(
  parameter int W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [CTL_W-1:0]      ctl_word,
  input logic [W-1:0]          data_in,
  input logic [W-1:0]          data_out,
  input logic                  flag_c,
  input logic                  flag_s,
  input logic                  flag_z,
  input logic                  flag_v,
  input logic [NUM_REGS*W-1:0] regs
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2: operand A from the input bus, passed through
  p_srcin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_word[13:11] == 3'b000 && ctl_word[4:0] == 5'b00000) |-> data_out == data_in);

  // R3: the selected register captures the result
  for (genvar k = 1; k <= NUM_REGS; k++) begin : g_wr
    p_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_word[7:5] == 3'(k)) |=> regs[(k-1)*W +: W] == $past(data_out));
  end

  // R4: destination 000 leaves every register untouched
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_word[7:5] == 3'b000) |=> $stable(regs));

  // R7: XOR of an operand with itself yields zero
  p_xorself_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_word[4:0] == 5'b01100 && ctl_word[13:11] == ctl_word[10:8]) |-> data_out == '0);

  // R10: zero and sign flags follow the previous cycle's result
  p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> flag_z == ($past(data_out) == '0));
  p_sign_r10: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> flag_s == $past(data_out[W-1]));

  // R11: logic functions clear carry and overflow
  p_logic_cv_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(ctl_word[4:0]) == 5'b01000) |-> (!flag_c && !flag_v));

endmodule

bind cwdp_core cwdp_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctl_word (ctl_word),
  .data_in  (data_in),
  .data_out (data_out),
  .flag_c   (flag_c),
  .flag_s   (flag_s),
  .flag_z   (flag_z),
  .flag_v   (flag_v),
  .regs     (rf_q)
);

// File: tb/sim_cwdp_core.sv
module sim_cwdp_core;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [13:0]  ctl_word;
  logic [W-1:0] data_in;
  logic [W-1:0] data_out;
  logic         flag_c, flag_s, flag_z, flag_v;

  int total = 0;
  int bad   = 0;

  logic [W-1:0] m [1:7];

  always #5 clk = ~clk;

  cwdp_core #(.W(W)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_word (ctl_word),
    .data_in  (data_in),
    .data_out (data_out),
    .flag_c   (flag_c),
    .flag_s   (flag_s),
    .flag_z   (flag_z),
    .flag_v   (flag_v)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Reference: returns {carry, overflow, result}
  function automatic logic [9:0] ref_fn(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b);
    int s;
    logic [7:0] r;
    logic c, v;
    c = 1'b0; v = 1'b0; r = a;
    case (op)
      5'b00001: begin s = int'(a) + 1; r = s[7:0]; c = s > 255; v = (a == 8'h7F); end
      5'b00010: begin s = int'(a) + int'(b); r = s[7:0]; c = s > 255;
                      v = (a[7] == b[7]) && (r[7] != a[7]); end
      5'b00101: begin s = int'(a) + int'(8'(~b)) + 1; r = s[7:0]; c = s > 255;
                      v = (a[7] != b[7]) && (r[7] != a[7]); end
      5'b00110: begin s = int'(a) + 255; r = s[7:0]; c = (a != 8'h00); v = (a == 8'h80); end
      5'b01000: r = a & b;
      5'b01010: r = a | b;
      5'b01100: r = a ^ b;
      5'b01110: r = ~a;
      5'b10000: begin r = a >> 1; c = a[0]; end
      5'b11000: begin r = a << 1; c = a[7]; end
      default:  r = a;
    endcase
    return {c, v, r};
  endfunction

  function automatic string tag_of(input logic [4:0] op);
    case (op)
      5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b00110: return "R6";
      5'b01000, 5'b01010, 5'b01100, 5'b01110:           return "R7";
      5'b10000, 5'b11000:                                return "R8";
      default:                                           return "R9";
    endcase
  endfunction

  function automatic string ftag_of(input logic [4:0] op);
    case (op)
      5'b00001, 5'b00010, 5'b00101, 5'b00110: return "R11";
      5'b10000, 5'b11000:                     return "R8";
      default:                                return "R10";
    endcase
  endfunction

  // One control word: result checked in-cycle, flags after the edge
  task automatic cyc(input logic [2:0] sa, input logic [2:0] sb, input logic [2:0] sd,
                     input logic [4:0] op, input logic [7:0] d, input string req);
    logic [7:0] a, b;
    logic [9:0] e;
    @(negedge clk);
    ctl_word = {sa, sb, sd, op};
    data_in  = d;
    a = (sa == 3'd0) ? d : m[sa];
    b = (sb == 3'd0) ? d : m[sb];
    e = ref_fn(op, a, b);
    #2;
    chk(req, 32'(data_out), 32'(e[7:0]));
    @(posedge clk);
    #1;
    chk(ftag_of(op), {28'd0, flag_c, flag_s, flag_z, flag_v},
        {28'd0, e[9], e[7], (e[7:0] == 8'h00), e[8]});
    if (sd != 3'd0) m[sd] = e[7:0];
  endtask

  task automatic read_all(input string req);
    for (int k = 1; k <= 7; k++) cyc(3'(k), 3'd0, 3'd0, 5'b00000, 8'hE7, req);
  endtask

  logic [7:0] vals [0:7];
  logic [4:0] ops  [0:12];

  initial begin
    vals = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h55, 8'hAA, 8'h3C};
    ops  = '{5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b00110, 5'b01000, 5'b01010,
             5'b01100, 5'b01110, 5'b10000, 5'b11000, 5'b00011, 5'b11111};
    for (int k = 1; k <= 7; k++) m[k] = 8'h00;
    rst_n    = 1'b0;
    ctl_word = '0;
    data_in  = '0;
    repeat (3) @(posedge clk);
    #1;
    // R12: flags cleared during reset
    chk("R12", {28'd0, flag_c, flag_s, flag_z, flag_v}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // R12: all registers read back as zero
    read_all("R12");

    // R2 / R5: input bus as operand, result visible without a write
    cyc(3'd0, 3'd0, 3'd0, 5'b00000, 8'hC3, "R5");
    cyc(3'd0, 3'd0, 3'd1, 5'b00000, 8'h96, "R2");
    cyc(3'd1, 3'd0, 3'd0, 5'b00010, 8'h11, "R2");

    // R1 / R3: every source and destination combination
    for (int k = 1; k <= 7; k++) cyc(3'd0, 3'd0, 3'(k), 5'b00000, 8'(k * 37 + 5), "R3");
    for (int sa = 0; sa < 8; sa++)
      for (int sb = 0; sb < 8; sb++)
        for (int sd = 0; sd < 8; sd++)
          cyc(3'(sa), 3'(sb), 3'(sd), 5'b00101, 8'(sa * 29 + sb * 11 + sd), "R1");
    read_all("R3");

    // R4: destination 000 changes no register
    cyc(3'd1, 3'd2, 3'd0, 5'b00010, 8'h00, "R4");
    cyc(3'd0, 3'd0, 3'd0, 5'b01110, 8'h5A, "R4");
    read_all("R4");

    // Operand / function sweep
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        cyc(3'd0, 3'd0, 3'd1, 5'b00000, vals[i], "R2");
        cyc(3'd0, 3'd0, 3'd2, 5'b00000, vals[j], "R2");
        for (int o = 0; o < 13; o++) begin
          cyc(3'd1, 3'd2, 3'd3, ops[o], 8'(i * 8 + j + o), tag_of(ops[o]));
          cyc(3'd3, 3'd0, 3'd0, 5'b00000, 8'h00, "R3");
        end
      end

    // Worked transfers: clear via self XOR, shift left in place, increment
    cyc(3'd0, 3'd0, 3'd5, 5'b00000, 8'h9D, "R2");
    cyc(3'd5, 3'd5, 3'd5, 5'b01100, 8'h00, "R7");
    cyc(3'd5, 3'd0, 3'd0, 5'b00000, 8'h00, "R7");
    cyc(3'd0, 3'd0, 3'd4, 5'b00000, 8'hC1, "R2");
    cyc(3'd4, 3'd0, 3'd4, 5'b11000, 8'h00, "R8");
    cyc(3'd4, 3'd0, 3'd0, 5'b00000, 8'h00, "R8");
    cyc(3'd4, 3'd5, 3'd4, 5'b01010, 8'h00, "R7");
    cyc(3'd0, 3'd0, 3'd6, 5'b00000, 8'hFF, "R2");
    cyc(3'd6, 3'd0, 3'd6, 5'b00001, 8'h00, "R11");
    cyc(3'd1, 3'd0, 3'd7, 5'b00000, 8'h00, "R6");
    read_all("R3");

    // R12: asynchronous reset in the middle of operation
    @(negedge clk);
    ctl_word = {3'd7, 3'd0, 3'd0, 5'b00000};
    #1;
    rst_n = 1'b0;
    #1;
    for (int k = 1; k <= 7; k++) m[k] = 8'h00;
    chk("R12", {28'd0, flag_c, flag_s, flag_z, flag_v}, 32'd0);
    chk("R12", 32'(data_out), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    read_all("R12");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_500_000;
    total++;
    bad++;
    $display("FAIL watchdog expired t=%0t", $time);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule